// File: doc/BRIEF.md
# Inset Picture Decimating Writer

This block shrinks a digitized inset video stream and writes the smaller copy into a field memory. It reduces the picture for a picture-in-picture overlay. The input is a 6-bit luma sample and two 6-bit color-difference samples per pixel. Three strobes go with them: a pixel-valid flag, a line-start strobe and a field-start strobe. The block averages each square group of 3x3 or 4x4 input pixels into one stored luma sample. The result is a picture of one-ninth or one-sixteenth of the original area.

Chroma is stored at a quarter of the luma rate. Each stored chroma sample averages one color-difference component over the span of four stored luma samples and over the same lines. B-Y and R-Y take turns from slot to slot. Stored samples go out on a single write port with a sequential address, so one stored line is a run of luma samples with a chroma sample after every fourth. Mode select and freeze are both sampled at field start. A field is therefore either written in full in one size or left untouched.

Top module: `pip_decimator`

## Requirements
- R1: With `mode_16`=0 at field start (one-ninth mode), the block writes floor(sum/9) of each 3x3 input luma block. Blocks are aligned to pixel 0 of the line and to line 0 of the field. The write happens on the third line of each 3-line group.
- R2: With `mode_16`=1 at field start (one-sixteenth mode), the block writes floor(sum/16) of each 4x4 input luma block. Blocks are aligned the same way, and the write happens on the fourth line of each 4-line group.
- R3: A stored line holds LINE_PIX/N luma samples (N = 3 or 4), so the default LINE_PIX=636 gives 212 in one-ninth mode. Valid pixels beyond the last complete group, and lines of an incomplete final group, produce no write.
- R4: After every fourth luma write of a line, one chroma sample is written in the next clock cycle. Its value is floor(sum/(4*N*N)) of one color-difference component over those 4*N pixels and N lines. A line of 212 luma samples thus gets 53 chroma samples.
- R5: Chroma slots alternate by component. Slot 0 of each line (the first after line start) holds B-Y (`cb_in`), slot 1 holds R-Y (`cr_in`), and so on.
- R6: The write address is 0 for the first write after a field start and rises by one for each write, luma and chroma alike.
- R7: `freeze` is sampled only at field start. A field that starts with freeze high gets no writes. Changing freeze in the middle of a field has no effect until the next field start.
- R8: `mode_16` is sampled only at field start. A change in the middle of a field does not alter that field's grouping.
- R9: A luma write appears on the memory port in the cycle after the clock edge that takes the last pixel of its group. A strobe cycle carries no pixel.
- R10: After reset, `mem_we` is 0 and `mem_addr` is 0, and no write happens before the first field start with freeze low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Pixel present this cycle |
| line_start | input | 1 | Start of a new line (no pixel in this cycle) |
| field_start | input | 1 | Start of a field and of its line 0 (no pixel) |
| y_in | input | 6 | Luma sample |
| cb_in | input | 6 | B-Y sample |
| cr_in | input | 6 | R-Y sample |
| mode_16 | input | 1 | 0: one-ninth size, 1: one-sixteenth size |
| freeze | input | 1 | Hold the stored picture from the next field |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | 6 | Memory write data |

## Verification
Luma writes are due one cycle after the edge that takes the completing pixel, and chroma writes two cycles after it. The bench records the drive cycle of each completing pixel and stores that cycle plus one or plus two next to the expected address and data. It then compares the cycle in which each write was actually seen at a falling edge. Freeze and mode effects are checked by counting the writes of each field against the count the bench predicts from the values present at that field's start.

// File: rtl/pip_decimator.sv
module pip_decimator #(
  parameter int LINE_PIX = 636,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_valid,
  input  logic              line_start,
  input  logic              field_start,
  input  logic [5:0]        y_in,
  input  logic [5:0]        cb_in,
  input  logic [5:0]        cr_in,
  input  logic              mode_16,
  input  logic              freeze,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [5:0]        mem_data
);
  localparam int LCOLS = LINE_PIX / 3;
  localparam int CCOLS = (LCOLS / 4 > 0) ? LCOLS / 4 : 1;
  localparam int CW    = $clog2(LCOLS + 1);
  localparam int CCW   = $clog2(CCOLS + 1);
  localparam logic [CW-1:0] LIM9  = CW'(LINE_PIX / 3);
  localparam logic [CW-1:0] LIM16 = CW'(LINE_PIX / 4);

  logic              mode_q, frozen, pend;
  logic [1:0]        hcnt, vline;
  logic [CW-1:0]     lcol;
  logic [CCW-1:0]    ccol;
  logic [7:0]        hl;
  logic [9:0]        hc;
  logic [ADDR_W-1:0] addr;
  logic [5:0]        pend_data;
  logic [9:0]        lacc [0:2**CW-1];
  logic [11:0]       cacc [0:2**CCW-1];

  wire [1:0]    nmax   = mode_q ? 2'd3 : 2'd2;
  wire [CW-1:0] lim    = mode_q ? LIM16 : LIM9;
  wire          take   = pix_valid && !field_start && !line_start && (lcol < lim);
  wire          hdone  = take && (hcnt == nmax);
  wire          cgrp   = (lcol[1:0] == 2'b11);
  wire          vfirst = (vline == 2'd0);
  wire          vlast  = (vline == nmax);
  wire [5:0]    csel   = ccol[0] ? cr_in : cb_in;
  wire [9:0]    lnew   = (vfirst ? 10'd0 : lacc[lcol]) + 10'(hl) + 10'(y_in);
  wire [11:0]   cnew   = (vfirst ? 12'd0 : cacc[ccol]) + 12'(hc) + 12'(csel);
  wire [9:0]    ldiv   = mode_q ? (lnew >> 4) : (lnew / 10'd9);
  wire [11:0]   cdiv   = mode_q ? (cnew >> 6) : (cnew / 12'd36);
  wire          store  = hdone && vlast && !frozen;

  always_ff @(posedge clk) begin
    if (hdone) begin
      lacc[lcol] <= lnew;
      if (cgrp) cacc[ccol] <= cnew;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      frozen    <= 1'b1;
      pend      <= 1'b0;
      pend_data <= '0;
      hcnt      <= '0;
      vline     <= '0;
      lcol      <= '0;
      ccol      <= '0;
      hl        <= '0;
      hc        <= '0;
      addr      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      mem_we <= 1'b0;
      pend   <= 1'b0;
      if (pend) begin
        mem_we   <= 1'b1;
        mem_addr <= addr;
        mem_data <= pend_data;
        addr     <= addr + 1'b1;
      end
      if (field_start) begin
        mode_q <= mode_16;
        frozen <= freeze;
        vline  <= '0;
        hcnt   <= '0;
        lcol   <= '0;
        ccol   <= '0;
        hl     <= '0;
        hc     <= '0;
        addr   <= '0;
      end else if (line_start) begin
        vline <= vlast ? 2'd0 : vline + 2'd1;
        hcnt  <= '0;
        lcol  <= '0;
        ccol  <= '0;
        hl    <= '0;
        hc    <= '0;
      end else if (take) begin
        if (hdone) begin
          hcnt <= '0;
          hl   <= '0;
          lcol <= lcol + 1'b1;
          if (cgrp) begin
            hc   <= '0;
            ccol <= ccol + 1'b1;
          end else begin
            hc <= hc + 10'(csel);
          end
          if (store) begin
            mem_we   <= 1'b1;
            mem_addr <= addr;
            mem_data <= ldiv[5:0];
            addr     <= addr + 1'b1;
            if (cgrp) begin
              pend      <= 1'b1;
              pend_data <= cdiv[5:0];
            end
          end
        end else begin
          hcnt <= hcnt + 2'd1;
          hl   <= hl + 8'(y_in);
          hc   <= hc + 10'(csel);
        end
      end
    end
  end
endmodule

// File: rtl/pip_decimator_chk.sv
module pip_decimator_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              line_start,
  input logic              field_start,
  input logic              freeze,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  logic              fresh, hold_q, hold_prev;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh     <= 1'b1;
      hold_q    <= 1'b1;
      hold_prev <= 1'b1;
      last_addr <= '0;
    end else begin
      hold_prev <= hold_q;
      if (mem_we) begin
        last_addr <= mem_addr;
        fresh     <= 1'b0;
      end
      if (field_start) begin
        hold_q <= freeze;
        fresh  <= 1'b1;
      end
    end
  end

  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !fresh) |-> (mem_addr == last_addr + 1'b1));

  a_r6_first_zero: assert property (@(posedge clk) disable iff (rst)
    (mem_we && fresh && !$past(mem_we)) |-> (mem_addr == '0));

  a_r7_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !(hold_q && hold_prev));

  a_r4_pair_only: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> !$past(mem_we, 2));

  a_r9_strobe_no_pixel: assert property (@(posedge clk) disable iff (rst)
    ($past(field_start || line_start) && mem_we) |-> $past(mem_we));
endmodule

bind pip_decimator pip_decimator_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .field_start(field_start),
  .freeze(freeze), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/pip_decimator_test.sv
module pip_decimator_test;
  localparam int LP = 24;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_valid = 1'b0, line_start = 1'b0, field_start = 1'b0;
  logic [5:0] y_in = '0, cb_in = '0, cr_in = '0;
  logic mode_16 = 1'b0, freeze = 1'b0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [5:0] mem_data;

  pip_decimator #(.LINE_PIX(LP), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .line_start(line_start),
    .field_start(field_start), .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .mode_16(mode_16), .freeze(freeze), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int checks = 0, errors = 0;
  int ncap = 0, nexp = 0;
  int cap_addr [0:4095];
  int cap_data [0:4095];
  int cap_cyc  [0:4095];
  int exp_addr [0:4095];
  int exp_data [0:4095];
  int exp_cyc  [0:4095];
  string exp_tag [0:4095];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && mem_we && ncap < 4096) begin
      cap_addr[ncap] = int'(mem_addr);
      cap_data[ncap] = int'(mem_data);
      cap_cyc[ncap]  = cyc;
      ncap++;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pix(input int seed, input int l, input int c, input int k);
    if (seed == 99) return 63;
    return (seed * 11 + l * 23 + c * 7 + k * 19 + l * c * 3) % 64;
  endfunction

  function automatic int luma_exp(input int seed, input int l, input int g, input int n);
    int s = 0;
    for (int r = l - n + 1; r <= l; r++)
      for (int c = g * n; c < g * n + n; c++) s += pix(seed, r, c, 0);
    return s / (n * n);
  endfunction

  function automatic int chroma_exp(input int seed, input int l, input int h, input int n);
    int s = 0;
    int k = 1 + (h % 2);
    for (int r = l - n + 1; r <= l; r++)
      for (int c = h * 4 * n; c < h * 4 * n + 4 * n; c++) s += pix(seed, r, c, k);
    return s / (4 * n * n);
  endfunction

  task automatic push(input int a, input int d, input int cy, input string t);
    exp_addr[nexp] = a; exp_data[nexp] = d; exp_cyc[nexp] = cy; exp_tag[nexp] = t;
    nexp++;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      pix_valid = 0; line_start = 0; field_start = 0;
    end
  endtask

  task automatic run_field(input int md, input int frz, input int seed, input int lines,
                           input int extra, input int gap, input int md_mid, input int frz_mid);
    int n = md ? 4 : 3;
    int lim = LP / n;
    int live = (frz == 0);
    int a = 0;
    int e0 = nexp;
    int c0 = ncap;
    string lt = md ? "R2" : "R1";
    @(negedge clk);
    pix_valid = 0; line_start = 0; field_start = 1;
    mode_16 = md[0]; freeze = frz[0];
    for (int l = 0; l < lines; l++) begin
      if (l > 0) begin
        @(negedge clk);
        pix_valid = 0; field_start = 0; line_start = 1;
      end
      for (int c = 0; c < LP + extra; c++) begin
        if (gap != 0 && c % 5 == 4) begin
          @(negedge clk);
          pix_valid = 0; field_start = 0; line_start = 0;
        end
        @(negedge clk);
        field_start = 0; line_start = 0; pix_valid = 1;
        mode_16 = md_mid[0];
        if (l == lines / 2) freeze = frz_mid[0];
        y_in = 6'(pix(seed, l, c, 0));
        cb_in = 6'(pix(seed, l, c, 1));
        cr_in = 6'(pix(seed, l, c, 2));
        if (live != 0 && l % n == n - 1 && c % n == n - 1 && c / n < lim) begin
          push(a, luma_exp(seed, l, c / n, n), cyc + 1, lt);
          a++;
          if ((c / n) % 4 == 3) begin
            push(a, chroma_exp(seed, l, (c / n) / 4, n), cyc + 2,
                 ((c / n) / 4) % 2 == 0 ? "R5" : "R4");
            a++;
          end
        end
      end
    end
    idle(5);
    check(live != 0 ? "R6" : "R7", "writes in field", ncap - c0, nexp - e0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10", "mem_we after reset", int'(mem_we), 0);
    check("R10", "mem_addr after reset", int'(mem_addr), 0);
    // R10: pixels and line strobes before any field start must not write
    for (int l = 0; l < 4; l++) begin
      @(negedge clk);
      pix_valid = 0; line_start = 1;
      for (int c = 0; c < LP; c++) begin
        @(negedge clk);
        line_start = 0; pix_valid = 1; y_in = 6'(c);
      end
    end
    idle(4);
    check("R10", "writes before first field start", ncap, 0);

    run_field(0, 0, 1, 6, 0, 0, 0, 0);   // R1 R4 R5 R6
    run_field(1, 0, 2, 8, 0, 0, 0, 1);   // R2 R8 (mode drops mid-field), R7 freeze raised mid-field
    run_field(0, 1, 3, 6, 0, 0, 0, 0);   // R7 frozen field, freeze dropped mid-field
    run_field(0, 0, 4, 7, 3, 1, 1, 0);   // R3 extra pixels, partial group, gaps, R8
    run_field(1, 0, 5, 9, 2, 1, 1, 0);   // R2 R3 gaps
    run_field(1, 0, 99, 4, 0, 0, 1, 0);  // R2 saturation 63
    run_field(0, 0, 99, 3, 0, 0, 0, 0);  // R1 saturation 63

    check("R3", "total write count", ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      check("R6", "address", cap_addr[i], exp_addr[i]);
      check(exp_tag[i], "data", cap_data[i], exp_data[i]);
      check("R9", "write cycle", cap_cyc[i], exp_cyc[i]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule